// File: doc/BRIEF.md
# Quadrature Integrate-and-Dump Phase Detector

This block measures how far an LC tank's response is from a quarter-cycle behind the square wave that drives it. Each system clock it compares the synchronized tank sense signal with the drive phase. It then adds a fixed positive step to a signed integrator when the two differ, and a fixed negative step when they match. With a 90-degree relationship the two cases occur equally often, so the integrated error averages to zero. The drive runs at about 2.25 to 2.31 MHz, and the phase relationship is always quadrature. There is no offset control.

An internally generated strobe decides when to dump. The block does not time the dump from external edges, so a noisy or late input transition cannot cause a glitched or missing dump. At each dump the integrator's value is split into two parts. The whole part, in output units, is saturated to a signed 16-bit word and registered, with a one-cycle valid pulse. The fractional remainder stays in the integrator. Error that is too small to show in one period therefore adds up and appears in a later period.

Top module: `quad_phase_det`

## Requirements
- R1: A synchronous active-high reset clears the output word to 0, drops the valid flag and empties the integrator, so the first dump after reset reflects only samples taken after reset.
- R2: The tank sense input passes through a two-stage register synchronizer. A level applied before rising edge k first affects the integration at edge k+2. Before that, the synchronizer supplies 0 after reset.
- R3: On every rising edge outside reset, the integrator gains +4 when the synchronized sense differs from the drive phase and -4 when they are equal.
- R4: When the dump strobe is high at an edge, that edge's own sample is included first. The output word then takes floor(sum / 8), where sum is the integrator value plus that sample. The valid flag is high for exactly the following cycle.
- R5: At a dump the integrator is reloaded with the carried remainder sum - 8*floor(sum/8), a value from 0 to 7. It is not reloaded with a constant.
- R6: The output word saturates at 32767 and -32768 when floor(sum/8) falls outside the signed 16-bit range. The remainder is still carried.
- R7: Without a dump the output word holds its value and valid stays low, whatever the sense and drive inputs do.
- R8: With sense trailing drive by a quarter period, every dump over a whole number of periods yields 0 once the synchronizer has filled.
- R9: A dump strobe held high on consecutive edges produces a new output and a valid pulse on each of them. For a constant match this gives the alternating sequence -1, 0, -1, 0, and that sequence depends on the carried remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_in | input | 1 | Square wave sensed from the tank, asynchronous |
| drive_ph | input | 1 | Drive phase, generated on-chip in the clock domain |
| dump | input | 1 | Internal dump strobe, one edge per dump |
| err_out | output | 16 | Signed phase error word, 0 at quadrature |
| err_valid | output | 1 | High for one cycle after each dump |

## Verification
The hardest case to reach is output saturation. The word only clips after roughly 65,500 clocks of one-sided error accumulated without a dump. The stimulus holds sense and drive in a fixed relationship through that whole interval, in both polarities, before it strobes the dump. The carried remainder is only visible in a chain of dumps, so the stimulus holds the strobe high on successive edges. It also uses a pseudo-random sense pattern with irregular dump spacing, which a reference model checks at every dump.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

    localparam int OUT_W       = 16;
    localparam int ACC_W       = 24;
    localparam int FRAC_W      = 3;
    localparam int GAIN        = 4;
    localparam int SYNC_STAGES = 2;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [OUT_W-1:0] word_t;

    typedef enum logic {
        PH_MATCH  = 1'b0,
        PH_DIFFER = 1'b1
    } ph_rel_e;

    typedef struct packed {
        logic fire;
        acc_t quot;
    } dump_req_t;

    localparam acc_t WORD_MAX = acc_t'((1 << (OUT_W - 1)) - 1);
    localparam acc_t WORD_MIN = -acc_t'(1 << (OUT_W - 1));
    localparam acc_t FRAC_SPAN = acc_t'(1 << FRAC_W);

    function automatic acc_t step_of(ph_rel_e rel);
        return (rel == PH_DIFFER) ? acc_t'(GAIN) : -acc_t'(GAIN);
    endfunction

    function automatic word_t clamp_word(acc_t v);
        if (v > WORD_MAX) return word_t'(WORD_MAX);
        if (v < WORD_MIN) return word_t'(WORD_MIN);
        return word_t'(v);
    endfunction

endpackage

// File: rtl/qpd_sync.sv
module qpd_sync
    import qpd_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    // R2: the synchronized level is the input from STAGES edges earlier
    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, STAGES)));

endmodule

// File: rtl/qpd_integrator.sv
module qpd_integrator
    import qpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ph_rel_e   rel,
    input  logic      dump,
    output dump_req_t req
);

    acc_t acc_q;
    acc_t sum;
    acc_t resid;

    always_comb begin
        sum      = acc_q + step_of(rel);
        resid    = acc_t'({{(ACC_W-FRAC_W){1'b0}}, sum[FRAC_W-1:0]});
        req.fire = dump;
        req.quot = sum >>> FRAC_W;
    end

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (dump) acc_q <= resid;
        else           acc_q <= sum;
    end

    // R3: between dumps the integrator moves by exactly one step of fixed size
    assert_step_size_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(dump)) |->
        ((acc_q - $past(acc_q) == acc_t'(GAIN)) || ($past(acc_q) - acc_q == acc_t'(GAIN))));

    // R5: after a dump only the fractional remainder stays in the integrator
    assert_residual_range_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dump)) |-> (acc_q >= 0 && acc_q < FRAC_SPAN));

endmodule

// File: rtl/qpd_out_reg.sv
module qpd_out_reg
    import qpd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dump_req_t req,
    output word_t     word,
    output logic      valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= req.fire;
            if (req.fire) word <= clamp_word(req.quot);
        end
    end

    // R4: valid only ever follows a dump request
    assert_valid_follows_dump_R4: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(req.fire));

    // R7: the word holds when no dump was requested
    assert_hold_between_dumps_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req.fire)) |-> $stable(word));

    // R6: an oversized positive quotient clips to the top of the range
    assert_clip_high_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req.fire) && ($past(req.quot) > WORD_MAX)) |->
        (word == word_t'(WORD_MAX)));

endmodule

// File: rtl/quad_phase_det.sv
module quad_phase_det
    import qpd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sense_in,
    input  logic                    drive_ph,
    input  logic                    dump,
    output logic signed [OUT_W-1:0] err_out,
    output logic                    err_valid
);

    logic      sense_s;
    ph_rel_e   rel;
    dump_req_t req;

    qpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sense_in),
        .q   (sense_s)
    );

    assign rel = ph_rel_e'(sense_s ^ drive_ph);

    qpd_integrator u_integ (
        .clk  (clk),
        .rst  (rst),
        .rel  (rel),
        .dump (dump),
        .req  (req)
    );

    qpd_out_reg u_out (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .word  (err_out),
        .valid (err_valid)
    );

endmodule

// File: tb/quad_phase_det_test.sv
module quad_phase_det_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sense_in = 1'b0;
    logic drive_ph = 1'b0;
    logic dump = 1'b0;
    logic signed [15:0] err_out;
    logic err_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    quad_phase_det uut (
        .clk       (clk),
        .rst       (rst),
        .sense_in  (sense_in),
        .drive_ph  (drive_ph),
        .dump      (dump),
        .err_out   (err_out),
        .err_valid (err_valid)
    );

    // Reference model built from the requirements
    logic   m1 = 1'b0, m2 = 1'b0;
    longint macc = 0;
    longint mout = 0;
    logic   mval = 1'b0;

    function automatic longint floor8(longint v);
        if (v >= 0) return v / 8;
        return -((-v + 7) / 8);
    endfunction

    always @(posedge clk) begin
        longint st, sum, q;
        if (rst) begin
            m1 = 1'b0; m2 = 1'b0; macc = 0; mout = 0; mval = 1'b0;
        end else begin
            st  = (m2 ^ drive_ph) ? 4 : -4;
            sum = macc + st;
            if (dump) begin
                q    = floor8(sum);
                macc = sum - q * 8;
                mout = (q > 32767) ? 32767 : ((q < -32768) ? -32768 : q);
                mval = 1'b1;
            end else begin
                macc = sum;
                mval = 1'b0;
            end
            m2 = m1;
            m1 = sense_in;
        end
    end

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(logic s, logic d);
        rst = 1'b1; dump = 1'b0; sense_in = s; drive_ph = d;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic fire_after(int n);
        repeat (n - 1) tick();
        dump = 1'b1;
        tick();
        dump = 1'b0;
    endtask

    task automatic t_in_phase();
        start(1'b0, 1'b0);
        fire_after(16);
        check("R3 match slope", err_out, -8);
        check("R4 valid after dump", err_valid, 1);
        tick();
        check("R4 valid single cycle", err_valid, 0);
        check("R7 word held", err_out, -8);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        check("R1 word cleared", err_out, 0);
        check("R1 valid cleared", err_valid, 0);
        rst = 1'b0;
    endtask

    task automatic t_anti_phase();
        start(1'b1, 1'b0);
        fire_after(16);
        check("R2 R3 differ slope with sync delay", err_out, 6);
    endtask

    task automatic t_back_to_back();
        start(1'b0, 1'b0);
        dump = 1'b1;
        tick(); check("R9 R5 dump 1", err_out, -1); check("R9 valid 1", err_valid, 1);
        tick(); check("R9 R5 dump 2", err_out, 0);  check("R9 valid 2", err_valid, 1);
        tick(); check("R9 R5 dump 3", err_out, -1);
        tick(); check("R9 R5 dump 4", err_out, 0);
        dump = 1'b0;
        start(1'b1, 1'b0);
        dump = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick();
            check("R5 carried remainder", err_out, mout);
        end
        dump = 1'b0;
    endtask

    task automatic t_hold();
        logic signed [15:0] keep;
        start(1'b1, 1'b0);
        fire_after(10);
        keep = err_out;
        for (int i = 0; i < 6; i++) begin
            sense_in = i[0];
            drive_ph = i[1];
            tick();
            check("R7 hold word", err_out, keep);
            check("R7 valid low", err_valid, 0);
        end
    endtask

    task automatic t_quadrature();
        start(1'b0, 1'b0);
        for (int p = 0; p < 64; p++) begin
            drive_ph = p[1];
            sense_in = (p[1] ^ p[0]) ? ~p[1] : p[1];
            sense_in = logic'(((p + 3) >> 1) & 1) ^ 1'b1;
            dump = (p % 8 == 7);
            tick();
            if (p % 8 == 7) begin
                check("R4 quadrature vs model", err_out, mout);
                if (p >= 23) check("R8 quadrature zero", err_out, 0);
            end
        end
        dump = 1'b0;
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        int gap = 0;
        start(1'b0, 1'b0);
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sense_in = lfsr[0];
            drive_ph = lfsr[5];
            gap++;
            dump = (gap >= 5 + int'(lfsr[9:7]));
            if (dump) gap = 0;
            tick();
            if (dump) check("R4 random vs model", err_out, mout);
            check("R4 valid vs model", err_valid, mval);
        end
        dump = 1'b0;
    endtask

    task automatic t_saturate();
        start(1'b1, 1'b0);
        fire_after(65600);
        check("R6 clip high", err_out, 32767);
        start(1'b0, 1'b0);
        fire_after(65600);
        check("R6 clip low", err_out, -32768);
        fire_after(2);
        check("R6 remainder kept after clip", err_out, -1);
    endtask

    initial begin
        @(negedge clk);
        tick();
        check("R1 reset word", err_out, 0);
        check("R1 reset valid", err_valid, 0);
        t_in_phase();
        t_reset();
        t_anti_phase();
        t_back_to_back();
        t_hold();
        t_quadrature();
        t_random();
        t_saturate();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule